// File: doc/BRIEF.md
# Palette Memory Access Gate

This block sits between the CPU port and a 512-byte palette store. The store holds 256 colours of 15 bits each, and each colour is kept as a low byte followed by a high byte. The block chooses the byte address and shapes the write data. It also shapes the read data that comes back from the store. The top bit of every high byte does not exist, so it is held at zero in both directions.

The block can also imitate contention with the renderer. When the redirect mode is on and the picture is not blanked, an access inside the visible beam window does not use the CPU address. It uses the renderer's current palette pointer instead, and bit 7 is cleared whatever the address parity. The visible window covers lines below 225, or below 240 with overscan, and horizontal counts 128 through 1095. With the mode off, or with forced blank on, every access goes straight to the CPU address.

The store is external and has one cycle of read latency. The block presents the address, write enable, read enable and write data in the same cycle as the CPU strobe. It returns the shaped read byte one cycle later and flags it with a valid pulse.

Top module: `pal_access_gate`

## Requirements
- R1: On the direct path, `mem_addr` equals `cpu_addr` (9 bits, byte 0 to 511) in the cycle of the strobe.
- R2: A direct write to an odd address (bit 0 = 1) stores `cpu_wdata` with bit 7 forced to 0. A direct write to an even address stores the byte unchanged.
- R3: A direct read returns the addressed byte on `cpu_rdata` in the cycle after the strobe. Bit 7 is forced to 0 when the address is odd and left as stored when it is even.
- R4: The access uses `int_addr` when all of these hold: `redir_en` = 1, `fblank` = 0, `vcnt` < 225 (or < 240 when `overscan` = 1), and 128 <= `hcnt` <= 1095. This applies to reads and writes alike.
- R5: A redirected access forces bit 7 to 0 in the written byte and in the returned byte, for even and odd CPU addresses alike.
- R6: With `fblank` = 1, every access takes the direct path, even inside the window.
- R7: With `redir_en` = 0, every access takes the direct path.
- R8: `mem_we` follows `cpu_wr`. `mem_re` follows `cpu_rd` when no write is present, because a write wins. `cpu_rvalid` is high in exactly the cycle after a read, and it is 0 in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 9 | CPU byte address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| hcnt | input | 11 | Horizontal beam count |
| vcnt | input | 9 | Vertical line count |
| overscan | input | 1 | Selects the 240-line visible height |
| fblank | input | 1 | Forced blank |
| redir_en | input | 1 | Enables beam-window redirection |
| int_addr | input | 9 | Renderer's palette byte pointer |
| mem_addr | output | 9 | Store byte address |
| mem_we | output | 1 | Store write enable |
| mem_re | output | 1 | Store read enable |
| mem_wdata | output | 8 | Store write byte |
| mem_rdata | input | 8 | Store read byte, one cycle after `mem_re` |
| cpu_rdata | output | 8 | Shaped read byte |
| cpu_rvalid | output | 1 | `cpu_rdata` is valid |

## Verification
The only state the block holds is the read-valid flag and the bit-7 clear decision registered from the read cycle. A wrong value in either one shows up on `cpu_rvalid` or `cpu_rdata[7]` in the cycle right after the read strobe. A window comparison that is off by one count shows up at once on `mem_addr` when the beam sits at an edge count. For that reason the bench places accesses at horizontal counts 127, 128, 1095 and 1096, and on the last and first lines either side of the height limit in both overscan settings.

// File: rtl/pal_access_gate.sv
module pal_access_gate #(
  parameter int AW          = 9,
  parameter int DW          = 8,
  parameter int HW          = 11,
  parameter int VW          = 9,
  parameter int H_FIRST     = 128,
  parameter int H_LAST      = 1095,
  parameter int V_LINES     = 225,
  parameter int V_LINES_OVS = 240
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  input  logic          overscan,
  input  logic          fblank,
  input  logic          redir_en,
  input  logic [AW-1:0] int_addr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_rvalid
);

  localparam int MSB = DW - 1;

  logic [VW-1:0] v_limit;
  logic          in_win;
  logic          clr_top;
  logic          clr_top_q;

  assign v_limit = overscan ? VW'(V_LINES_OVS) : VW'(V_LINES);

  assign in_win = redir_en && !fblank && (vcnt < v_limit) &&
                  (hcnt >= HW'(H_FIRST)) && (hcnt <= HW'(H_LAST));

  assign clr_top = in_win || cpu_addr[0];

  assign mem_addr  = in_win ? int_addr : cpu_addr;
  assign mem_we    = cpu_wr;
  assign mem_re    = cpu_rd && !cpu_wr;
  assign mem_wdata = {cpu_wdata[MSB] & ~clr_top, cpu_wdata[MSB-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rvalid <= 1'b0;
      clr_top_q  <= 1'b0;
    end else begin
      cpu_rvalid <= mem_re;
      if (mem_re) clr_top_q <= clr_top;
    end
  end

  assign cpu_rdata = {mem_rdata[MSB] & ~clr_top_q, mem_rdata[MSB-1:0]};

  AST_ODD_WRITE_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[0]) |-> !mem_wdata[MSB]); // R2

  AST_ODD_READ_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_wr && cpu_addr[0]) |=> !cpu_rdata[MSB]); // R3

  AST_BLANK_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    fblank |-> (mem_addr == cpu_addr)); // R6

  AST_NOREDIR_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_en |-> (mem_addr == cpu_addr && mem_wdata[MSB-1:0] == cpu_wdata[MSB-1:0])); // R7

  AST_REDIR_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && redir_en && !fblank && !overscan && vcnt < VW'(V_LINES) &&
     hcnt >= HW'(H_FIRST) && hcnt <= HW'(H_LAST)) |-> (!mem_wdata[MSB] && mem_addr == int_addr)); // R5

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> cpu_rvalid); // R8

  AST_RVALID_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_re |=> !cpu_rvalid); // R8

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |-> (mem_we && !mem_re)); // R8

endmodule

// File: tb/pal_access_gate_tb_top.sv
module pal_access_gate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic       cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [10:0] hcnt = '0;
  logic [8:0] vcnt = '0;
  logic       overscan = 1'b0, fblank = 1'b0, redir_en = 1'b0;
  logic [8:0] int_addr = '0;
  logic [8:0] mem_addr;
  logic       mem_we, mem_re;
  logic [7:0] mem_wdata, mem_rdata, cpu_rdata;
  logic       cpu_rvalid;

  logic [7:0] store [512];
  logic [7:0] rd_q = '0;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pal_access_gate dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .hcnt(hcnt), .vcnt(vcnt),
    .overscan(overscan), .fblank(fblank), .redir_en(redir_en), .int_addr(int_addr),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid)
  );

  assign mem_rdata = rd_q;

  always @(posedge clk) begin
    if (mem_we) store[mem_addr] <= mem_wdata;
    if (mem_re) rd_q <= store[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic set_beam(input int h, input int v, input bit ovs, input bit fb,
                          input bit en, input logic [8:0] ia);
    hcnt = 11'(h); vcnt = 9'(v); overscan = ovs; fblank = fb; redir_en = en; int_addr = ia;
  endtask

  task automatic do_write(input logic [8:0] a, input logic [7:0] d, input bit redir,
                          input string req);
    logic [8:0] ea;
    logic [7:0] ed;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    ea = redir ? int_addr : a;
    ed = (redir || a[0]) ? (d & 8'h7f) : d;
    #1;
    chk(mem_we === 1'b1 && mem_re === 1'b0, req, {mem_we, mem_re}, 2'b10);
    chk(mem_addr === ea, req, mem_addr, ea);
    chk(mem_wdata === ed, req, mem_wdata, ed);
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic do_read(input logic [8:0] a, input bit redir, input string req);
    logic [8:0] ea;
    logic [7:0] ed;
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    ea = redir ? int_addr : a;
    ed = (redir || a[0]) ? (store[ea] & 8'h7f) : store[ea];
    #1;
    chk(mem_re === 1'b1 && mem_addr === ea, req, mem_addr, ea);
    @(negedge clk);
    cpu_rd = 1'b0;
    chk(cpu_rvalid === 1'b1, req, cpu_rvalid, 1);
    chk(cpu_rdata === ed, req, cpu_rdata, ed);
    @(negedge clk);
    chk(cpu_rvalid === 1'b0, req, cpu_rvalid, 0);
  endtask

  task automatic t_reset;
    #1;
    chk(cpu_rvalid === 1'b0, "R8 reset", cpu_rvalid, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk(cpu_rvalid === 1'b0, "R8 after reset", cpu_rvalid, 0);
  endtask

  task automatic t_direct;
    set_beam(500, 100, 0, 0, 0, 9'h155);
    do_write(9'h010, 8'hA5, 0, "R1 R2 even write");
    do_write(9'h011, 8'hFF, 0, "R2 odd write");
    do_write(9'h1FE, 8'h80, 0, "R1 top even write");
    store[9'h1FF] = 8'hC3;
    store[9'h022] = 8'hC3;
    do_read(9'h022, 0, "R3 even read");
    do_read(9'h1FF, 0, "R3 odd read");
    do_read(9'h010, 0, "R3 readback");
  endtask

  task automatic t_window;
    store[9'h0A0] = 8'hF0;
    store[9'h040] = 8'hEE;
    set_beam(127, 10, 0, 0, 1, 9'h0A0);
    do_write(9'h040, 8'h9C, 0, "R4 h=127 outside");
    set_beam(128, 10, 0, 0, 1, 9'h0A0);
    do_write(9'h040, 8'h9C, 1, "R4 R5 h=128 inside");
    set_beam(1095, 10, 0, 0, 1, 9'h0A2);
    do_write(9'h041, 8'hB7, 1, "R4 R5 h=1095 inside");
    set_beam(1096, 10, 0, 0, 1, 9'h0A2);
    do_write(9'h042, 8'hB7, 0, "R4 h=1096 outside");
    store[9'h0A4] = 8'hFF;
    set_beam(600, 224, 0, 0, 1, 9'h0A4);
    do_read(9'h044, 1, "R4 R5 v=224 inside");
    set_beam(600, 225, 0, 0, 1, 9'h0A4);
    store[9'h044] = 8'hFF;
    do_read(9'h044, 0, "R4 v=225 outside");
    set_beam(600, 239, 1, 0, 1, 9'h0A4);
    do_read(9'h044, 1, "R4 R5 ovs v=239 inside");
    set_beam(600, 240, 1, 0, 1, 9'h0A4);
    do_read(9'h044, 0, "R4 ovs v=240 outside");
    set_beam(600, 230, 1, 0, 1, 9'h0A6);
    do_write(9'h046, 8'hD1, 1, "R4 ovs v=230 inside");
  endtask

  task automatic t_blank;
    set_beam(600, 50, 0, 1, 1, 9'h0B0);
    do_write(9'h050, 8'hC8, 0, "R6 fblank write");
    store[9'h051] = 8'h8F;
    do_read(9'h050, 0, "R6 fblank read");
  endtask

  task automatic t_disabled;
    set_beam(600, 50, 0, 0, 0, 9'h0B0);
    do_write(9'h060, 8'hFE, 0, "R7 disabled write");
    do_read(9'h060, 0, "R7 disabled read");
  endtask

  task automatic t_both_strobes;
    set_beam(600, 250, 0, 0, 0, 9'h000);
    @(negedge clk);
    cpu_addr = 9'h070; cpu_wdata = 8'h12; cpu_wr = 1'b1; cpu_rd = 1'b1;
    #1;
    chk(mem_we === 1'b1 && mem_re === 1'b0, "R8 write wins", {mem_we, mem_re}, 2'b10);
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
    chk(cpu_rvalid === 1'b0, "R8 no valid after write", cpu_rvalid, 0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) store[i] = 8'(i * 7);
    t_reset();
    t_direct();
    t_window();
    t_blank();
    t_disabled();
    t_both_strobes();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++;
      misses++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule